// File: doc/BRIEF.md
# Display Converter Mode Register Bank and Wide Pixel Formatter

This block holds the sixteen byte-wide control registers of a display colour converter and turns one of them, the format register at index 0xB, into a pixel-format selection for scan-out. Software writes a code byte into that register; a fixed code map converts it into a 3-bit format number. The format number goes to the rest of the display pipeline, which uses it to choose how memory words are unpacked. Several codes map to the same format, and any code outside the map falls back to 8 bits per pixel.

The block also formats the two 32-bit pixel layouts itself. A memory word arrives with a valid strobe. One clock later the block presents a 24-bit RGB pixel with its own valid strobe. In plain 32 bpp the pixel is the low three bytes of the word. In the RGBA layout the low byte is dropped and the top three bytes are kept. For the narrower formats the block only reports the format number and produces no pixels.

Top module: `ramdac_mode_fmt`

## Requirements
- R1: The bank has 16 byte registers selected by `acc_addr[3:0]`; higher address bits are ignored. A write with `acc_we` high takes effect at the clock edge. `acc_rdata` always shows the current content of the register that `acc_addr[3:0]` selects.
- R2: While `rst` is high and after it is released, all registers read 0x00, `fmt_mode` is 1 (8 bpp) and `pix_out_valid` is low.
- R3: `fmt_mode` uses this encoding: 0 = 4 bpp, 1 = 8 bpp, 2 = 15 bpp, 3 = 16 bpp, 4 = 24 bpp, 5 = 32 bpp, 6 = RGBA8888. Register 0xB holding 0x82 gives 0, 0x83 gives 1 and 0xA0 gives 2.
- R4: Register 0xB holding 0xA1 or 0xB1 gives 3. Holding 0xC0 or 0xD0 gives 4. Holding 0xE2 gives 5, and holding 0xF2 gives 6.
- R5: Any other value in register 0xB gives `fmt_mode` = 1.
- R6: A write to any register other than 0xB leaves `fmt_mode` unchanged.
- R7: In format 5, a word accepted with `pix_in_valid` appears one cycle later as `pix_out_rgb` = word[23:0], with `pix_out_valid` high.
- R8: In format 6, a word accepted with `pix_in_valid` appears one cycle later as `pix_out_rgb` = word[31:8], with `pix_out_valid` high.
- R9: `pix_out_valid` is low in the cycle after any cycle in which `pix_in_valid` is low or the format is 0 to 4.
- R10: A word is formatted with the format in force in the cycle it is presented. A word presented in the same cycle as a write to register 0xB uses the old format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_we | input | 1 | Register write strobe |
| acc_addr | input | 16 | Access address; only the low 4 bits select a register |
| acc_wdata | input | 8 | Register write data |
| acc_rdata | output | 8 | Content of the addressed register |
| fmt_mode | output | 3 | Decoded pixel format number |
| pix_in_valid | input | 1 | Memory word strobe |
| pix_in_word | input | 32 | Memory word |
| pix_out_valid | output | 1 | Formatted pixel strobe |
| pix_out_rgb | output | 24 | Formatted 24-bit pixel |

## Verification
The hardest case to reach is a write to the format register that lands in the same cycle as a pixel word. The word must use the old format, and the next word must use the new one. The bench streams words in RGBA mode and overlaps one of them with a write of the 32 bpp code, then checks both pixels. The bench also writes every one of the 256 byte values into the format register, so that each alias and the whole fallback range are covered.

// File: rtl/ramdac_mode_pkg.sv
package ramdac_mode_pkg;

    typedef enum logic [2:0] {
        FMT_4    = 3'd0,
        FMT_8    = 3'd1,
        FMT_15   = 3'd2,
        FMT_16   = 3'd3,
        FMT_24   = 3'd4,
        FMT_32   = 3'd5,
        FMT_RGBA = 3'd6
    } pix_fmt_e;

    localparam int unsigned CODE_W = 8;

    function automatic pix_fmt_e fmt_from_code(input logic [CODE_W-1:0] code);
        unique case (code)
            8'h82:        return FMT_4;
            8'h83:        return FMT_8;
            8'hA0:        return FMT_15;
            8'hA1, 8'hB1: return FMT_16;
            8'hC0, 8'hD0: return FMT_24;
            8'hE2:        return FMT_32;
            8'hF2:        return FMT_RGBA;
            default:      return FMT_8;
        endcase
    endfunction

    function automatic logic fmt_is_wide(input pix_fmt_e f);
        return (f == FMT_32) || (f == FMT_RGBA);
    endfunction

endpackage

// File: rtl/ramdac_reg_bank.sv
module ramdac_reg_bank #(
    parameter int unsigned REG_AW   = 4,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned MODE_IDX = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mode_code
);
    localparam int unsigned NREG = 1 << REG_AW;

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && idx == REG_AW'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata     = regs[idx];
    assign mode_code = regs[MODE_IDX];
endmodule

// File: rtl/ramdac_mode_decode.sv
module ramdac_mode_decode
    import ramdac_mode_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output pix_fmt_e          fmt,
    output logic              wide
);
    always_comb begin
        fmt  = fmt_from_code(code);
        wide = fmt_is_wide(fmt);
    end
endmodule

// File: rtl/ramdac_pix_fmt.sv
module ramdac_pix_fmt
    import ramdac_mode_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned PIX_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  pix_fmt_e          fmt,
    input  logic              wide,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_rgb
);
    localparam int unsigned DROP = WORD_W - PIX_W;

    logic [PIX_W-1:0] low_part;
    logic [PIX_W-1:0] high_part;
    logic [DROP-1:0]  unused_mid;

    assign low_part   = in_word[PIX_W-1:0];
    assign high_part  = in_word[WORD_W-1:DROP];
    assign unused_mid = in_word[DROP-1:0] ^ in_word[WORD_W-1:PIX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= in_valid && wide;
            if (in_valid && wide) begin
                out_rgb <= (fmt == FMT_RGBA) ? high_part : low_part;
            end
        end
    end
endmodule

// File: rtl/ramdac_mode_fmt.sv
module ramdac_mode_fmt
    import ramdac_mode_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned REG_AW   = 4,
    parameter int unsigned MODE_IDX = 11,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned PIX_W    = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic [2:0]        fmt_mode,
    input  logic              pix_in_valid,
    input  logic [WORD_W-1:0] pix_in_word,
    output logic              pix_out_valid,
    output logic [PIX_W-1:0]  pix_out_rgb
);
    logic [CODE_W-1:0] mode_code;
    pix_fmt_e          cur_fmt;
    logic              cur_wide;
    logic              unused_hi;

    assign unused_hi = ^acc_addr[ADDR_W-1:REG_AW];

    ramdac_reg_bank #(
        .REG_AW  (REG_AW),
        .DATA_W  (CODE_W),
        .MODE_IDX(MODE_IDX)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (acc_we),
        .idx      (acc_addr[REG_AW-1:0]),
        .wdata    (acc_wdata),
        .rdata    (acc_rdata),
        .mode_code(mode_code)
    );

    ramdac_mode_decode u_dec (
        .code(mode_code),
        .fmt (cur_fmt),
        .wide(cur_wide)
    );

    ramdac_pix_fmt #(
        .WORD_W(WORD_W),
        .PIX_W (PIX_W)
    ) u_fmt (
        .clk      (clk),
        .rst      (rst),
        .fmt      (cur_fmt),
        .wide     (cur_wide),
        .in_valid (pix_in_valid),
        .in_word  (pix_in_word),
        .out_valid(pix_out_valid),
        .out_rgb  (pix_out_rgb)
    );

    assign fmt_mode = cur_fmt;
endmodule

// File: rtl/ramdac_mode_fmt_chk.sv
module ramdac_mode_fmt_chk #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned REG_AW   = 4,
    parameter int unsigned MODE_IDX = 11,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned PIX_W    = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_we,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [7:0]        acc_wdata,
    input logic [7:0]        acc_rdata,
    input logic [2:0]        fmt_mode,
    input logic              pix_in_valid,
    input logic [WORD_W-1:0] pix_in_word,
    input logic              pix_out_valid,
    input logic [PIX_W-1:0]  pix_out_rgb
);
    logic unused_hi;
    assign unused_hi = ^acc_addr[ADDR_W-1:REG_AW];

    // R2: reset gives 8 bpp and no output strobe
    a_r2_reset_state: assert property (@(posedge clk)
        rst |=> (fmt_mode == 3'd1 && !pix_out_valid));

    // R1: written data reads back on the same register index
    a_r1_write_readback: assert property (@(posedge clk) disable iff (rst)
        acc_we |=> (acc_addr[REG_AW-1:0] != $past(acc_addr[REG_AW-1:0])
                    || acc_rdata == $past(acc_wdata)));

    // R6: writes elsewhere leave the format alone
    a_r6_mode_kept: assert property (@(posedge clk) disable iff (rst)
        (!acc_we || acc_addr[REG_AW-1:0] != REG_AW'(MODE_IDX)) |=> $stable(fmt_mode));

    // R4: 32 bpp code
    a_r4_code_e2: assert property (@(posedge clk) disable iff (rst)
        (acc_we && acc_addr[REG_AW-1:0] == REG_AW'(MODE_IDX) && acc_wdata == 8'hE2)
        |=> fmt_mode == 3'd5);

    // R7: 32 bpp keeps the low three bytes
    a_r7_low_bytes: assert property (@(posedge clk) disable iff (rst)
        (pix_in_valid && fmt_mode == 3'd5)
        |=> (pix_out_valid && pix_out_rgb == $past(pix_in_word[PIX_W-1:0])));

    // R8: RGBA drops the low byte
    a_r8_drop_low: assert property (@(posedge clk) disable iff (rst)
        (pix_in_valid && fmt_mode == 3'd6)
        |=> (pix_out_valid && pix_out_rgb == $past(pix_in_word[WORD_W-1:WORD_W-PIX_W])));

    // R9: no strobe without a wide-format input word
    a_r9_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (!pix_in_valid || fmt_mode < 3'd5) |=> !pix_out_valid);

    // R3: format number stays within the encoded range
    a_r3_range: assert property (@(posedge clk) disable iff (rst)
        fmt_mode != 3'd7);
endmodule

bind ramdac_mode_fmt ramdac_mode_fmt_chk #(
    .ADDR_W(ADDR_W), .REG_AW(REG_AW), .MODE_IDX(MODE_IDX),
    .WORD_W(WORD_W), .PIX_W(PIX_W)
) u_chk (
    .clk(clk), .rst(rst), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .fmt_mode(fmt_mode),
    .pix_in_valid(pix_in_valid), .pix_in_word(pix_in_word),
    .pix_out_valid(pix_out_valid), .pix_out_rgb(pix_out_rgb)
);

// File: tb/ramdac_mode_fmt_bench.sv
module ramdac_mode_fmt_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_we = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic [2:0]  fmt_mode;
    logic        pix_in_valid = 1'b0;
    logic [31:0] pix_in_word = '0;
    logic        pix_out_valid;
    logic [23:0] pix_out_rgb;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    ramdac_mode_fmt u_ramdac_mode_fmt (
        .clk(clk), .rst(rst), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .fmt_mode(fmt_mode),
        .pix_in_valid(pix_in_valid), .pix_in_word(pix_in_word),
        .pix_out_valid(pix_out_valid), .pix_out_rgb(pix_out_rgb)
    );

    function automatic logic [2:0] exp_mode(input logic [7:0] v);
        logic [2:0] m;
        m = 3'd1;
        if (v == 8'h82) m = 3'd0;
        if (v == 8'hA0) m = 3'd2;
        if (v == 8'hA1 || v == 8'hB1) m = 3'd3;
        if (v == 8'hC0 || v == 8'hD0) m = 3'd4;
        if (v == 8'hE2) m = 3'd5;
        if (v == 8'hF2) m = 3'd6;
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    function automatic logic [31:0] word_of(input int m, input int k);
        return (32'h9E3779B9 * (k + 1)) ^ (32'h01000193 * (m + 3));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] prev;
        // R2: state during reset
        repeat (3) @(negedge clk);
        check("R2 mode", {29'd0, fmt_mode}, 32'd1);
        check("R2 valid", {31'd0, pix_out_valid}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            acc_addr = 16'(i);
            #1 check("R2 reg zero", {24'd0, acc_rdata}, 32'd0);
        end
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 mode after release", {29'd0, fmt_mode}, 32'd1);

        // R1: fill all registers through aliased addresses, read back via others
        for (int i = 0; i < 16; i++)
            reg_write({12'(i * 37 + 5), 4'(i)}, 8'((i * 29 + 11) & 255));
        for (int i = 0; i < 16; i++) begin
            acc_addr = {12'(i * 91 + 1000), 4'(i)};
            #1 check("R1 readback", {24'd0, acc_rdata}, 32'((i * 29 + 11) & 255));
        end

        // R6: writes to other registers keep the format
        reg_write(16'h000B, 8'hE2);
        for (int i = 0; i < 16; i++) begin
            if (i != 11) begin
                reg_write({12'hABC, 4'(i)}, 8'hF2);
                check("R6 mode kept", {29'd0, fmt_mode}, 32'd5);
            end
        end

        // R3 R4 R5: all code values, through upper-bit aliases of index 0xB
        for (int v = 0; v < 256; v++) begin
            reg_write({12'(v * 7), 4'hB}, 8'(v));
            if (exp_mode(8'(v)) == 3'd1 && v != 8'h83)
                check("R5 fallback", {29'd0, fmt_mode}, 32'd1);
            else if (v == 8'h82 || v == 8'h83 || v == 8'hA0)
                check("R3 code", {29'd0, fmt_mode}, {29'd0, exp_mode(8'(v))});
            else
                check("R4 code", {29'd0, fmt_mode}, {29'd0, exp_mode(8'(v))});
        end

        // R7 R8 R9: stream words in each format
        for (int m = 0; m < 7; m++) begin
            logic [7:0] code;
            case (m)
                0: code = 8'h82; 1: code = 8'h83; 2: code = 8'hA0; 3: code = 8'hB1;
                4: code = 8'hD0; 5: code = 8'hE2; default: code = 8'hF2;
            endcase
            reg_write(16'h000B, code);
            for (int k = 0; k < 9; k++) begin
                @(negedge clk);
                if (k > 0) begin
                    if (m == 5) begin
                        check("R7 valid", {31'd0, pix_out_valid}, 32'd1);
                        check("R7 pixel", {8'd0, pix_out_rgb}, {8'd0, prev[23:0]});
                    end else if (m == 6) begin
                        check("R8 valid", {31'd0, pix_out_valid}, 32'd1);
                        check("R8 pixel", {8'd0, pix_out_rgb}, {8'd0, prev[31:8]});
                    end else begin
                        check("R9 narrow", {31'd0, pix_out_valid}, 32'd0);
                    end
                end
                if (k < 8) begin
                    prev = word_of(m, k);
                    pix_in_valid = 1'b1;
                    pix_in_word  = prev;
                end else begin
                    pix_in_valid = 1'b0;
                end
            end
            @(negedge clk);
            check("R9 idle", {31'd0, pix_out_valid}, 32'd0);
        end

        // R10: format switch overlapping a pixel word
        reg_write(16'h000B, 8'hF2);
        @(negedge clk);
        pix_in_valid = 1'b1; pix_in_word = 32'hA1B2C3D4;
        acc_we = 1'b1; acc_addr = 16'h000B; acc_wdata = 8'hE2;
        @(negedge clk);
        acc_we = 1'b0;
        check("R10 old format", {8'd0, pix_out_rgb}, 32'h00A1B2C3);
        pix_in_word = 32'h55667788;
        @(negedge clk);
        pix_in_valid = 1'b0;
        check("R10 new format", {8'd0, pix_out_rgb}, 32'h00667788);
        check("R10 mode", {29'd0, fmt_mode}, 32'd5);

        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule